// File: doc/BRIEF.md
# I2C Master Message Transaction Sequencer

This block carries out one whole I2C master transaction on its own once the host has set it going. The host fills a small message buffer and hands over a length, then pulses a go input. Entry 0 of the buffer is the 7-bit target address with the read/write bit in bit 0. The length counts that entry along with the payload. The sequencer then drives a byte-level bus engine. It issues START, byte write, byte read (with ACK or NACK), repeated START and STOP commands, and it reacts to the single status code the engine returns after each command.

On a write the payload bytes are taken from the buffer in order. On a read the received bytes are stored back into buffer entries 1 through length-1. Every received byte is acknowledged except the last one, which gets a NACK. When arbitration is lost the sequencer restarts the whole message with a repeated START. A NACK or a bus error stops the transfer and latches the exact failing status code. While busy is low the host may read the buffer back, or reuse it unchanged to send the same message again.

Top module: `i2c_msg_sequencer`

## Requirements
- R1: After reset, busy, done_ok and eng_cmd_valid are 0 and err_code is 0.
- R2: A go pulse while idle with msg_len from 1 to 16 raises busy, clears done_ok and err_code, and issues a START command on the next cycle. Command codes on eng_cmd: 1 START, 2 repeated START, 3 WRITE (byte on eng_wdata), 4 READ answered with ACK, 5 READ answered with NACK, 6 STOP. Each command is a one-cycle eng_cmd_valid pulse.
- R3: A go pulse with msg_len 0 or above 16 issues no command, leaves busy low and done_ok low, and sets err_code to 15.
- R4: Engine status codes on eng_stat, valid while eng_stat_valid is high: 1 START sent, 2 repeated START sent, 3 address+W ACKed, 4 address+W NACKed, 5 data written ACKed, 6 data written NACKed, 7 arbitration lost, 8 address+R ACKed, 9 address+R NACKed, 10 data read with ACK sent, 11 data read with NACK sent, 12 bus error. After code 1 or 2 the next command is WRITE of buffer entry 0.
- R5: After code 3 or 5 the next buffer entry is written, in index order. Once every entry up to length-1 has been acknowledged, a STOP is issued, done_ok becomes 1 and busy falls, all on the same cycle.
- R6: After code 8 the sequencer issues READ commands. Each one is code 4 except the read of entry length-1, which is code 5. The bytes returned with codes 10 and 11 are stored into entries 1, 2, ... in order. Code 11 ends the transfer with STOP and done_ok=1.
- R7: Code 7 makes the next command a repeated START with busy held, and the message is then sent again from entry 0.
- R8: Codes 4, 6, 9 and 12 produce a STOP, drop busy, leave done_ok at 0 and set err_code to that exact code.
- R9: While busy, host buffer writes and go pulses are ignored.
- R10: A second go with the same length and no reload sends the same bytes again.
- R11: With length 1, address acknowledgement (code 3 or 8) is followed directly by STOP with done_ok=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Buffer write strobe (ignored while busy) |
| host_addr | input | 4 | Buffer entry index for write and readback |
| host_wdata | input | 8 | Buffer write data |
| host_rdata | output | 8 | Buffer readback of entry host_addr |
| msg_len | input | 5 | Message length including the address entry |
| go | input | 1 | Start pulse |
| busy | output | 1 | Transaction in progress |
| done_ok | output | 1 | Last transaction completed successfully |
| err_code | output | 4 | Latched failing status (0 when none) |
| eng_cmd_valid | output | 1 | Command pulse to the byte engine |
| eng_cmd | output | 3 | Command code |
| eng_wdata | output | 8 | Byte to transmit with WRITE |
| eng_stat_valid | input | 1 | Engine status pulse |
| eng_stat | input | 4 | Engine status code |
| eng_rdata | input | 8 | Byte received by the engine |

## Verification
Write messages of one and three entries separate the case where the address acknowledgement ends the transfer from the case where it leads on to further writes. Reads of one, two and four entries show where the switch from ACK to NACK falls. The four-entry read also confirms the store order through readback. An arbitration loss in the middle of a write shows that the retry starts again from entry 0 and not from where it stopped. Each error code is injected at its own point in the transfer to confirm that the exact code is latched, and lengths 0 and 17 probe both edges of the range check.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NONE      = 3'd0,
    CMD_START     = 3'd1,
    CMD_RSTART    = 3'd2,
    CMD_WRITE     = 3'd3,
    CMD_READ_ACK  = 3'd4,
    CMD_READ_NACK = 3'd5,
    CMD_STOP      = 3'd6
  } cmd_e;

  typedef enum logic [3:0] {
    ST_NONE        = 4'd0,
    ST_START_DONE  = 4'd1,
    ST_RSTART_DONE = 4'd2,
    ST_AW_ACK      = 4'd3,
    ST_AW_NACK     = 4'd4,
    ST_DW_ACK      = 4'd5,
    ST_DW_NACK     = 4'd6,
    ST_ARB_LOST    = 4'd7,
    ST_AR_ACK      = 4'd8,
    ST_AR_NACK     = 4'd9,
    ST_DR_ACK      = 4'd10,
    ST_DR_NACK     = 4'd11,
    ST_BUS_ERR     = 4'd12,
    ST_BAD_LEN     = 4'd15
  } stat_e;

  // a message must hold at least the address entry and fit the buffer
  function automatic logic len_in_range(int unsigned len, int unsigned depth);
    return (len != 0) && (len <= depth);
  endfunction

  // the read that fills entry idx is acknowledged unless idx is the last entry
  function automatic logic read_wants_ack(int unsigned idx, int unsigned len);
    return (idx + 1) < len;
  endfunction

endpackage

// File: rtl/msg_buf.sv
module msg_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          seq_we,
  input  logic [AW-1:0] seq_widx,
  input  logic [DW-1:0] seq_wdata,
  input  logic [AW-1:0] seq_ridx,
  output logic [DW-1:0] seq_rdata
);

  logic [DW-1:0] entry [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry[g] <= '0;
      end else if (seq_we && seq_widx == AW'(g)) begin
        entry[g] <= seq_wdata;
      end else if (host_we && host_addr == AW'(g)) begin
        entry[g] <= host_wdata;
      end
    end
  end

  assign host_rdata = entry[host_addr];
  assign seq_rdata  = entry[seq_ridx];

endmodule

// File: rtl/cmd_issue.sv
module cmd_issue
  import i2c_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  cmd_e          cmd_in,
  input  logic [DW-1:0] data_in,
  output logic          valid_o,
  output cmd_e          cmd_o,
  output logic [DW-1:0] data_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      cmd_o   <= CMD_NONE;
      data_o  <= '0;
    end else begin
      valid_o <= issue;
      if (issue) begin
        cmd_o  <= cmd_in;
        data_o <= data_in;
      end
    end
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter int DEPTH   = 16,
  localparam int AW     = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             stat_valid,
  input  logic [3:0]       stat,
  output logic [AW-1:0]    rd_idx,
  output logic             wr_en,
  output logic [AW-1:0]    wr_idx,
  output logic             issue,
  output cmd_e             issue_cmd,
  output logic             busy,
  output logic             done_ok,
  output logic [3:0]       err_code,
  output logic             ev_accept,
  output logic             ev_reject,
  output logic             ev_retry,
  output logic             ev_finish
);

  logic [LEN_W-1:0] ptr, ptr_n, len_q, len_n;
  logic             busy_n, ok_n;
  logic [3:0]       err_n;
  logic [LEN_W-1:0] ptr_inc;

  assign ptr_inc = ptr + LEN_W'(1);
  assign wr_idx  = ptr[AW-1:0];

  always_comb begin
    ptr_n     = ptr;
    len_n     = len_q;
    busy_n    = busy;
    ok_n      = done_ok;
    err_n     = err_code;
    issue     = 1'b0;
    issue_cmd = CMD_NONE;
    rd_idx    = ptr[AW-1:0];
    wr_en     = 1'b0;
    ev_accept = 1'b0;
    ev_reject = 1'b0;
    ev_retry  = 1'b0;
    ev_finish = 1'b0;
    if (!busy) begin
      if (go) begin
        ok_n = 1'b0;
        if (len_in_range(32'(msg_len), DEPTH)) begin
          busy_n    = 1'b1;
          err_n     = ST_NONE;
          len_n     = msg_len;
          ptr_n     = '0;
          issue     = 1'b1;
          issue_cmd = CMD_START;
          ev_accept = 1'b1;
        end else begin
          err_n     = ST_BAD_LEN;
          ev_reject = 1'b1;
        end
      end
    end else if (stat_valid) begin
      case (stat)
        ST_START_DONE, ST_RSTART_DONE: begin
          rd_idx    = '0;
          issue     = 1'b1;
          issue_cmd = CMD_WRITE;
          ptr_n     = LEN_W'(1);
        end
        ST_AW_ACK, ST_DW_ACK: begin
          issue = 1'b1;
          if (ptr < len_q) begin
            issue_cmd = CMD_WRITE;
            ptr_n     = ptr_inc;
          end else begin
            issue_cmd = CMD_STOP;
            busy_n    = 1'b0;
            ok_n      = 1'b1;
            ev_finish = 1'b1;
          end
        end
        ST_AR_ACK: begin
          issue = 1'b1;
          if (ptr < len_q) begin
            issue_cmd = read_wants_ack(32'(ptr), 32'(len_q)) ? CMD_READ_ACK : CMD_READ_NACK;
          end else begin
            issue_cmd = CMD_STOP;
            busy_n    = 1'b0;
            ok_n      = 1'b1;
            ev_finish = 1'b1;
          end
        end
        ST_DR_ACK: begin
          wr_en     = 1'b1;
          ptr_n     = ptr_inc;
          issue     = 1'b1;
          issue_cmd = read_wants_ack(32'(ptr_inc), 32'(len_q)) ? CMD_READ_ACK : CMD_READ_NACK;
        end
        ST_DR_NACK: begin
          wr_en     = 1'b1;
          issue     = 1'b1;
          issue_cmd = CMD_STOP;
          busy_n    = 1'b0;
          ok_n      = 1'b1;
          ev_finish = 1'b1;
        end
        ST_ARB_LOST: begin
          issue     = 1'b1;
          issue_cmd = CMD_RSTART;
          ev_retry  = 1'b1;
        end
        default: begin
          issue     = 1'b1;
          issue_cmd = CMD_STOP;
          busy_n    = 1'b0;
          ok_n      = 1'b0;
          err_n     = stat;
          ev_finish = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      len_q    <= '0;
      busy     <= 1'b0;
      done_ok  <= 1'b0;
      err_code <= ST_NONE;
    end else begin
      ptr      <= ptr_n;
      len_q    <= len_n;
      busy     <= busy_n;
      done_ok  <= ok_n;
      err_code <= err_n;
    end
  end

endmodule

// File: rtl/i2c_msg_sequencer.sv
module i2c_msg_sequencer
  import i2c_seq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DW     = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [AW-1:0]    host_addr,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             go,
  output logic             busy,
  output logic             done_ok,
  output logic [3:0]       err_code,
  output logic             eng_cmd_valid,
  output logic [2:0]       eng_cmd,
  output logic [DW-1:0]    eng_wdata,
  input  logic             eng_stat_valid,
  input  logic [3:0]       eng_stat,
  input  logic [DW-1:0]    eng_rdata
);

  logic [AW-1:0] rd_idx, wr_idx;
  logic          wr_en, issue;
  cmd_e          issue_cmd, cmd_q;
  logic [DW-1:0] seq_rdata;
  logic          ev_accept, ev_reject, ev_retry, ev_finish;

  msg_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we && !busy),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .seq_we     (wr_en),
    .seq_widx   (wr_idx),
    .seq_wdata  (eng_rdata),
    .seq_ridx   (rd_idx),
    .seq_rdata  (seq_rdata)
  );

  seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .msg_len    (msg_len),
    .stat_valid (eng_stat_valid),
    .stat       (eng_stat),
    .rd_idx     (rd_idx),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .issue      (issue),
    .issue_cmd  (issue_cmd),
    .busy       (busy),
    .done_ok    (done_ok),
    .err_code   (err_code),
    .ev_accept  (ev_accept),
    .ev_reject  (ev_reject),
    .ev_retry   (ev_retry),
    .ev_finish  (ev_finish)
  );

  cmd_issue #(.DW(DW)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .cmd_in  (issue_cmd),
    .data_in (seq_rdata),
    .valid_o (eng_cmd_valid),
    .cmd_o   (cmd_q),
    .data_o  (eng_wdata)
  );

  assign eng_cmd = cmd_q;

endmodule

// File: rtl/seq_checker.sv
module seq_checker
  import i2c_seq_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic [LEN_W-1:0] msg_len,
  input logic             busy,
  input logic             done_ok,
  input logic [3:0]       err_code,
  input logic             eng_cmd_valid,
  input logic [2:0]       eng_cmd,
  input logic             eng_stat_valid,
  input logic [3:0]       eng_stat,
  input logic             ev_accept,
  input logic             ev_reject,
  input logic             ev_retry,
  input logic             ev_finish
);

  assert_accept_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> eng_cmd_valid && eng_cmd == CMD_START && busy && !done_ok && err_code == 4'd0);

  assert_bad_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy && (msg_len == 0 || 32'(msg_len) > DEPTH)) |=>
      !busy && !eng_cmd_valid && err_code == ST_BAD_LEN);

  assert_start_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_stat_valid && (eng_stat == ST_START_DONE || eng_stat == ST_RSTART_DONE)) |=>
      eng_cmd_valid && eng_cmd == CMD_WRITE);

  assert_ok_with_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_ok) |-> eng_cmd_valid && eng_cmd == CMD_STOP && !busy);

  assert_retry_rstart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_stat_valid && eng_stat == ST_ARB_LOST) |=>
      eng_cmd_valid && eng_cmd == CMD_RSTART && busy);

  assert_error_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_stat_valid && (eng_stat == ST_AW_NACK || eng_stat == ST_DW_NACK ||
                                eng_stat == ST_AR_NACK || eng_stat == ST_BUS_ERR)) |=>
      eng_cmd_valid && eng_cmd == CMD_STOP && !busy && !done_ok && err_code == $past(eng_stat));

  assert_ok_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> err_code == 4'd0);

  assert_cmd_inside_txn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_cmd_valid && eng_cmd != CMD_STOP) |-> busy);

  assert_single_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_accept, ev_reject, ev_retry, ev_finish}));

endmodule

bind i2c_msg_sequencer seq_checker #(.DEPTH(DEPTH)) u_seq_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .go             (go),
  .msg_len        (msg_len),
  .busy           (busy),
  .done_ok        (done_ok),
  .err_code       (err_code),
  .eng_cmd_valid  (eng_cmd_valid),
  .eng_cmd        (eng_cmd),
  .eng_stat_valid (eng_stat_valid),
  .eng_stat       (eng_stat),
  .ev_accept      (ev_accept),
  .ev_reject      (ev_reject),
  .ev_retry       (ev_retry),
  .ev_finish      (ev_finish)
);

// File: tb/test_i2c_msg_sequencer.sv
module test_i2c_msg_sequencer;

  localparam int C_START = 1, C_RST = 2, C_WR = 3, C_RDA = 4, C_RDN = 5, C_STOP = 6;
  localparam int S_START = 1, S_RST = 2, S_AWA = 3, S_AWN = 4, S_DWA = 5, S_DWN = 6,
                 S_ARB = 7, S_ARA = 8, S_ARN = 9, S_DRA = 10, S_DRN = 11, S_BUS = 12,
                 E_LEN = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [4:0] msg_len = '0;
  logic       go = 1'b0;
  logic       busy, done_ok;
  logic [3:0] err_code;
  logic       eng_cmd_valid;
  logic [2:0] eng_cmd;
  logic [7:0] eng_wdata;
  logic       eng_stat_valid = 1'b0;
  logic [3:0] eng_stat = '0;
  logic [7:0] eng_rdata = '0;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  i2c_msg_sequencer i_i2c_msg_sequencer (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .msg_len(msg_len), .go(go),
    .busy(busy), .done_ok(done_ok), .err_code(err_code),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd), .eng_wdata(eng_wdata),
    .eng_stat_valid(eng_stat_valid), .eng_stat(eng_stat), .eng_rdata(eng_rdata)
  );

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  task automatic load(input int idx, input int val);
    @(negedge clk);
    host_we = 1'b1; host_addr = 4'(idx); host_wdata = 8'(val);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic readback(input string tag, input int idx, input int exp);
    host_addr = 4'(idx);
    #1;
    chk(tag, int'(host_rdata), exp);
  endtask

  // pulse go; returns at the negedge where the START command is visible
  task automatic kick(input int len);
    @(negedge clk);
    go = 1'b1; msg_len = 5'(len);
    @(negedge clk);
    go = 1'b0;
  endtask

  // waits (from the current negedge) for a command pulse and checks it
  task automatic expect_cmd(input string tag, input int cmd, input int data);
    bit seen = 0;
    for (int i = 0; i < 8; i++) begin
      if (eng_cmd_valid) begin seen = 1; break; end
      @(negedge clk);
    end
    if (!seen) begin
      chk({tag, " cmd pulse"}, 0, 1);
    end else begin
      chk({tag, " cmd"}, int'(eng_cmd), cmd);
      if (data >= 0) chk({tag, " wdata"}, int'(eng_wdata), data);
    end
  endtask

  // engine answers: status visible for one cycle, returns one negedge later
  task automatic resp(input int code, input int rdata);
    eng_stat_valid = 1'b1; eng_stat = 4'(code); eng_rdata = 8'(rdata);
    @(negedge clk);
    eng_stat_valid = 1'b0;
  endtask

  task automatic end_state(input string tag, input int ok, input int err);
    chk({tag, " busy"}, int'(busy), 0);
    chk({tag, " done_ok"}, int'(done_ok), ok);
    chk({tag, " err_code"}, int'(err_code), err);
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done_ok", int'(done_ok), 0);
    chk("R1 err_code", int'(err_code), 0);
    chk("R1 cmd_valid", int'(eng_cmd_valid), 0);
  endtask

  task automatic t_write3();
    load(0, 8'hA4); load(1, 8'h11); load(2, 8'h22);
    kick(3);
    chk("R2 busy", int'(busy), 1);
    chk("R2 done_ok cleared", int'(done_ok), 0);
    expect_cmd("R2 start", C_START, -1);
    resp(S_START, 0);
    expect_cmd("R4 addr", C_WR, 8'hA4);
    resp(S_AWA, 0);
    expect_cmd("R5 byte1", C_WR, 8'h11);
    resp(S_DWA, 0);
    expect_cmd("R5 byte2", C_WR, 8'h22);
    resp(S_DWA, 0);
    expect_cmd("R5 stop", C_STOP, -1);
    end_state("R5 end", 1, 0);
  endtask

  task automatic t_resend();
    kick(3);
    expect_cmd("R10 start", C_START, -1);
    resp(S_START, 0);
    expect_cmd("R10 addr", C_WR, 8'hA4);
    resp(S_AWA, 0);
    expect_cmd("R10 byte1", C_WR, 8'h11);
    resp(S_DWA, 0);
    expect_cmd("R10 byte2", C_WR, 8'h22);
    resp(S_DWA, 0);
    expect_cmd("R10 stop", C_STOP, -1);
    end_state("R10 end", 1, 0);
  endtask

  task automatic t_read4();
    load(0, 8'hA5);
    kick(4);
    expect_cmd("R6 start", C_START, -1);
    resp(S_START, 0);
    expect_cmd("R6 addr", C_WR, 8'hA5);
    resp(S_ARA, 0);
    expect_cmd("R6 read1 ack", C_RDA, -1);
    resp(S_DRA, 8'h3C);
    expect_cmd("R6 read2 ack", C_RDA, -1);
    resp(S_DRA, 8'h5D);
    expect_cmd("R6 read3 nack", C_RDN, -1);
    resp(S_DRN, 8'h7E);
    expect_cmd("R6 stop", C_STOP, -1);
    end_state("R6 end", 1, 0);
    readback("R6 entry1", 1, 8'h3C);
    readback("R6 entry2", 2, 8'h5D);
    readback("R6 entry3", 3, 8'h7E);
    readback("R6 entry0 kept", 0, 8'hA5);
  endtask

  task automatic t_read2();
    kick(2);
    expect_cmd("R6 r2 start", C_START, -1);
    resp(S_START, 0);
    expect_cmd("R6 r2 addr", C_WR, 8'hA5);
    resp(S_ARA, 0);
    expect_cmd("R6 r2 single nack", C_RDN, -1);
    resp(S_DRN, 8'h99);
    expect_cmd("R6 r2 stop", C_STOP, -1);
    end_state("R6 r2 end", 1, 0);
    readback("R6 r2 entry1", 1, 8'h99);
  endtask

  task automatic t_len1();
    load(0, 8'hA4);
    kick(1);
    expect_cmd("R11 w start", C_START, -1);
    resp(S_START, 0);
    expect_cmd("R11 w addr", C_WR, 8'hA4);
    resp(S_AWA, 0);
    expect_cmd("R11 w stop", C_STOP, -1);
    end_state("R11 w end", 1, 0);
    load(0, 8'hA5);
    kick(1);
    expect_cmd("R11 r start", C_START, -1);
    resp(S_START, 0);
    expect_cmd("R11 r addr", C_WR, 8'hA5);
    resp(S_ARA, 0);
    expect_cmd("R11 r stop", C_STOP, -1);
    end_state("R11 r end", 1, 0);
  endtask

  task automatic t_arb();
    load(0, 8'h40); load(1, 8'h77);
    kick(2);
    expect_cmd("R7 start", C_START, -1);
    resp(S_START, 0);
    expect_cmd("R7 addr", C_WR, 8'h40);
    resp(S_AWA, 0);
    expect_cmd("R7 byte1", C_WR, 8'h77);
    resp(S_ARB, 0);
    expect_cmd("R7 rstart", C_RST, -1);
    chk("R7 busy held", int'(busy), 1);
    resp(S_RST, 0);
    expect_cmd("R7 retry addr", C_WR, 8'h40);
    resp(S_AWA, 0);
    expect_cmd("R7 retry byte1", C_WR, 8'h77);
    resp(S_DWA, 0);
    expect_cmd("R7 stop", C_STOP, -1);
    end_state("R7 end", 1, 0);
  endtask

  task automatic t_errors();
    kick(2);
    expect_cmd("R8 a start", C_START, -1);
    resp(S_START, 0);
    expect_cmd("R8 a addr", C_WR, 8'h40);
    resp(S_AWN, 0);
    expect_cmd("R8 a stop", C_STOP, -1);
    end_state("R8 addr nack", 0, S_AWN);
    kick(2);
    chk("R2 err cleared", int'(err_code), 0);
    expect_cmd("R8 d start", C_START, -1);
    resp(S_START, 0);
    expect_cmd("R8 d addr", C_WR, 8'h40);
    resp(S_AWA, 0);
    expect_cmd("R8 d byte", C_WR, 8'h77);
    resp(S_DWN, 0);
    expect_cmd("R8 d stop", C_STOP, -1);
    end_state("R8 data nack", 0, S_DWN);
    load(0, 8'h41);
    kick(2);
    expect_cmd("R8 r start", C_START, -1);
    resp(S_START, 0);
    expect_cmd("R8 r addr", C_WR, 8'h41);
    resp(S_ARN, 0);
    expect_cmd("R8 r stop", C_STOP, -1);
    end_state("R8 read addr nack", 0, S_ARN);
    kick(2);
    expect_cmd("R8 b start", C_START, -1);
    resp(S_BUS, 0);
    expect_cmd("R8 b stop", C_STOP, -1);
    end_state("R8 bus error", 0, S_BUS);
  endtask

  task automatic t_badlen();
    kick(0);
    chk("R3 len0 cmd", int'(eng_cmd_valid), 0);
    end_state("R3 len0", 0, E_LEN);
    kick(17);
    chk("R3 len17 cmd", int'(eng_cmd_valid), 0);
    end_state("R3 len17", 0, E_LEN);
    @(negedge clk);
    chk("R3 still quiet", int'(eng_cmd_valid), 0);
  endtask

  task automatic t_busy_ignore();
    load(0, 8'h40); load(1, 8'h33);
    kick(2);
    expect_cmd("R9 start", C_START, -1);
    host_we = 1'b1; host_addr = 4'd1; host_wdata = 8'hFF; go = 1'b1; msg_len = 5'd0;
    @(negedge clk);
    host_we = 1'b0; go = 1'b0;
    chk("R9 busy kept", int'(busy), 1);
    chk("R9 no extra cmd", int'(eng_cmd_valid), 0);
    chk("R9 err untouched", int'(err_code), 0);
    resp(S_START, 0);
    expect_cmd("R9 addr", C_WR, 8'h40);
    resp(S_AWA, 0);
    expect_cmd("R9 byte unchanged", C_WR, 8'h33);
    resp(S_DWA, 0);
    expect_cmd("R9 stop", C_STOP, -1);
    end_state("R9 end", 1, 0);
    readback("R9 entry1 unchanged", 1, 8'h33);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write3();
    t_resend();
    t_read4();
    t_read2();
    t_len1();
    t_arb();
    t_errors();
    t_badlen();
    t_busy_ignore();
    repeat (3) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule